// File: doc/BRIEF.md
# Two-Instruction Word Fetch Sequencer

This block is the instruction fetch front end of an accumulator machine. Its memory holds 40-bit words, and each word packs two 20-bit instructions. The block reads one word at a time from a memory with a fixed one-cycle read latency. It hands the two instructions to a downstream execute stage one at a time, over a valid/ready pair. The second instruction of each word stays in a local buffer register, so it issues without another memory read.

A program counter names the next word to fetch and advances once per word read. It wraps back to zero at the top of the 1000-word space. The execute stage can redirect fetch with a jump request. A jump gives a 12-bit word address and selects which half of that word runs first. A jump discards any instruction that is buffered or being offered. When the right half is selected, only the right instruction of the target word issues.

Top module: `dual_fetch_seq`

## Requirements
- R1: After synchronous reset the program counter is 0 and the buffer is empty. In the first cycle after reset, a read request is raised for address 0 and no instruction is offered.
- R2: A read request (`mem_req`) lasts one cycle and carries the program counter on `mem_addr`. The block samples `mem_rdata` on the next cycle. The first instruction from that word is offered exactly two cycles after the request.
- R3: The left instruction is bits 39:20 of the word and issues first. Its opcode is bits 39:32, its address field is bits 31:20, and `iss_half` is 0.
- R4: Once the left instruction is accepted, the right instruction is offered from the buffer on the next cycle. Its opcode is bits 19:12, its address field is bits 11:0, and `iss_half` is 1. No read request is raised while an instruction is offered or pending in the buffer.
- R5: An offered instruction stays valid and unchanged until `iss_ready` accepts it, unless a jump intervenes.
- R6: The program counter advances by one for each word fetched. The cycle after the right instruction is accepted, a request is raised for the following word.
- R7: A word fetched from an address of 999 or above is followed by a fetch from address 0.
- R8: A jump (`jmp_valid`) takes priority over everything else. It clears the buffer, drops any offered instruction, and raises a request for `jmp_target` on the next cycle.
- R9: A jump with `jmp_right` = 1 issues only the right instruction of the target word. Fetch then continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory read request strobe |
| mem_addr | output | 12 | Word address of the read |
| mem_rdata | input | 40 | Read word, valid one cycle after the request |
| iss_valid | output | 1 | An instruction is offered |
| iss_ready | input | 1 | Execute stage accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Address field of the offered instruction |
| iss_half | output | 1 | 0 = left instruction, 1 = right instruction |
| jmp_valid | input | 1 | Jump request |
| jmp_target | input | 12 | Word address to jump to |
| jmp_right | input | 1 | Start at the right instruction of the target word |

## Verification
The properties assume that the memory always returns data one cycle after a request. They also assume the execute stage never needs an accepted instruction and a jump on the same edge. For that reason, every hold and ordering property is conditioned on the absence of a jump. The bench memory is an always-ready model with exactly one cycle of latency. The bench forces `iss_ready` low in any cycle where it raises a jump, so it never tests the jump-versus-accept race. Random jump targets cover the whole 12-bit range, including addresses at or beyond the 999 wrap point.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int WORD_W        = 40;
    localparam int HALF_W        = WORD_W / 2;
    localparam int OP_W          = 8;
    localparam int ADDR_W        = HALF_W - OP_W;
    localparam int MEM_WORDS_DEF = 1000;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } fstate_e;

    function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] pc,
                                                  input int unsigned       words);
        if (pc >= ADDR_W'(words - 1))
            return '0;
        return pc + 1'b1;
    endfunction

    function automatic instr_t left_of(input logic [WORD_W-1:0] w);
        return instr_t'(w[WORD_W-1 -: HALF_W]);
    endfunction

    function automatic instr_t right_of(input logic [WORD_W-1:0] w);
        return instr_t'(w[HALF_W-1:0]);
    endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int unsigned MEM_WORDS = MEM_WORDS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              jmp_valid,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              jmp_right,
    input  logic              fire,
    output fstate_e           state,
    output logic [ADDR_W-1:0] pc
);

    logic skip_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_FETCH;
            pc        <= '0;
            skip_left <= 1'b0;
        end else if (jmp_valid) begin
            state     <= ST_FETCH;
            pc        <= jmp_target;
            skip_left <= jmp_right;
        end else begin
            case (state)
                ST_FETCH: begin
                    state <= ST_WAIT;
                    pc    <= pc_step(pc, MEM_WORDS);
                end
                ST_WAIT: begin
                    state     <= skip_left ? ST_RIGHT : ST_LEFT;
                    skip_left <= 1'b0;
                end
                ST_LEFT: begin
                    if (fire)
                        state <= ST_RIGHT;
                end
                ST_RIGHT: begin
                    if (fire)
                        state <= ST_FETCH;
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/instr_buf.sv
module instr_buf
    import fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic              consume,
    input  logic [WORD_W-1:0] rdata,
    output instr_t            left_q,
    output instr_t            ibr_q,
    output logic              ibr_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            ibr_q  <= '0;
        end else if (load) begin
            left_q <= left_of(rdata);
            ibr_q  <= right_of(rdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            ibr_valid <= 1'b0;
        else if (load)
            ibr_valid <= 1'b1;
        else if (consume)
            ibr_valid <= 1'b0;
    end

endmodule

// File: rtl/issue_mux.sv
module issue_mux
    import fetch_pkg::*;
(
    input  fetch_pkg::fstate_e state,
    input  instr_t             left_q,
    input  instr_t             ibr_q,
    output logic               valid,
    output instr_t             instr,
    output logic               half
);

    always_comb begin
        valid = 1'b0;
        half  = 1'b0;
        instr = '0;
        case (state)
            ST_LEFT: begin
                valid = 1'b1;
                instr = left_q;
            end
            ST_RIGHT: begin
                valid = 1'b1;
                half  = 1'b1;
                instr = ibr_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dual_fetch_seq.sv
module dual_fetch_seq
    import fetch_pkg::*;
#(
    parameter int unsigned MEM_WORDS = MEM_WORDS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_opcode,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              iss_half,
    input  logic              jmp_valid,
    input  logic [ADDR_W-1:0] jmp_target,
    input  logic              jmp_right
);

    fstate_e           state;
    logic [ADDR_W-1:0] pc;
    instr_t            left_q;
    instr_t            ibr_q;
    instr_t            cur;
    logic              buf_valid;
    logic              fire;

    assign fire = iss_valid && iss_ready;

    fetch_ctrl #(.MEM_WORDS(MEM_WORDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .jmp_valid  (jmp_valid),
        .jmp_target (jmp_target),
        .jmp_right  (jmp_right),
        .fire       (fire),
        .state      (state),
        .pc         (pc)
    );

    instr_buf u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (jmp_valid),
        .load      (state == ST_WAIT),
        .consume   (fire && state == ST_RIGHT),
        .rdata     (mem_rdata),
        .left_q    (left_q),
        .ibr_q     (ibr_q),
        .ibr_valid (buf_valid)
    );

    issue_mux u_mux (
        .state  (state),
        .left_q (left_q),
        .ibr_q  (ibr_q),
        .valid  (iss_valid),
        .instr  (cur),
        .half   (iss_half)
    );

    assign mem_req    = (state == ST_FETCH);
    assign mem_addr   = pc;
    assign iss_opcode = cur.op;
    assign iss_addr   = cur.addr;

endmodule

// File: rtl/fetch_seq_checker.sv
module fetch_seq_checker
    import fetch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [OP_W-1:0]   iss_opcode,
    input logic [ADDR_W-1:0] iss_addr,
    input logic              iss_half,
    input logic              jmp_valid,
    input logic [ADDR_W-1:0] jmp_target,
    input logic              buf_valid
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mem_req && mem_addr == '0 && !iss_valid && !buf_valid));

    a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !jmp_valid) |=> (!mem_req && !iss_valid));

    a_r3_left_then_right: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !iss_half && !jmp_valid) |=> (iss_valid && iss_half));

    a_r4_no_read_while_issuing: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !mem_req);

    a_r4_right_from_buffer: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_half) |-> buf_valid);

    a_r5_offer_held: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !jmp_valid) |=>
            (iss_valid && $stable(iss_opcode) && $stable(iss_addr) && $stable(iss_half)));

    a_r6_fetch_after_right: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && iss_half && !jmp_valid) |=> (mem_req && !iss_valid));

    a_r8_jump_redirect: assert property (@(posedge clk) disable iff (rst)
        jmp_valid |=> (mem_req && !buf_valid && mem_addr == $past(jmp_target)));

endmodule

bind dual_fetch_seq fetch_seq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_opcode (iss_opcode),
    .iss_addr   (iss_addr),
    .iss_half   (iss_half),
    .jmp_valid  (jmp_valid),
    .jmp_target (jmp_target),
    .buf_valid  (buf_valid)
);

// File: tb/dual_fetch_seq_tb.sv
module dual_fetch_seq_tb;
    import fetch_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic [39:0] mem_rdata = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [7:0]  iss_opcode;
    logic [11:0] iss_addr;
    logic        iss_half;
    logic        jmp_valid = 1'b0;
    logic [11:0] jmp_target = '0;
    logic        jmp_right = 1'b0;

    always #5 clk = ~clk;

    dual_fetch_seq u_dut (
        .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_opcode(iss_opcode), .iss_addr(iss_addr), .iss_half(iss_half),
        .jmp_valid(jmp_valid), .jmp_target(jmp_target), .jmp_right(jmp_right)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int req_cyc = 0;
    int issued = 0;
    logic [11:0] exp_word = '0;
    bit exp_half = 0, in_right = 0, just_jumped = 0, wrapped = 0, from_rjump = 0;
    bit prev_valid = 0, prev_fire = 0, prev_jmp = 0, prev_half = 0;
    logic [7:0]  prev_op = '0;
    logic [11:0] prev_addr = '0;

    function automatic logic [39:0] memf(input logic [11:0] a);
        return {8'(a * 7 + 3), 12'(a ^ 12'hA5C), 8'(a * 13 + 91), 12'(a + 12'h321)};
    endfunction

    function automatic logic [11:0] stepw(input logic [11:0] w);
        return (w >= 12'd999) ? 12'd0 : w + 12'd1;
    endfunction

    always_ff @(posedge clk)
        if (mem_req) mem_rdata <= memf(mem_addr);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic tick(input int ready_pct, input bit rnd_jump,
                        input bit fj = 0, input logic [11:0] ft = '0, input bit fr = 0);
        bit jump, rdy, rsel;
        logic [11:0] tgt;
        @(negedge clk);
        cyc++;
        if (prev_valid && !prev_fire && !prev_jmp)
            check(iss_valid && iss_opcode == prev_op && iss_addr == prev_addr && iss_half == prev_half,
                  "R5", "held offer", {iss_valid, iss_half, iss_opcode, iss_addr},
                  {1'b1, prev_half, prev_op, prev_addr});
        if (iss_valid && !prev_valid)
            check(cyc - req_cyc == 2, "R2", "request to offer cycles", cyc - req_cyc, 2);
        if (mem_req) begin
            req_cyc = cyc;
            check(mem_addr == exp_word, just_jumped ? "R8" : (wrapped ? "R7" : "R6"),
                  "fetch address", mem_addr, exp_word);
            check(!in_right, "R4", "read while right half pending", in_right, 0);
            just_jumped = 0;
            wrapped = 0;
        end
        jump = fj || (rnd_jump && $urandom_range(0, 19) == 0);
        rdy = 0;
        rsel = fr;
        tgt = ft;
        if (jump) begin
            if (!fj) begin
                tgt  = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(995, 1002))
                                                   : 12'($urandom_range(0, 4095));
                rsel = 1'($urandom_range(0, 1));
            end
            exp_word = tgt; exp_half = rsel; in_right = 0;
            just_jumped = 1; wrapped = 0; from_rjump = rsel;
        end else begin
            rdy = ($urandom_range(0, 99) < ready_pct);
            if (iss_valid && rdy) begin
                logic [39:0] w = memf(exp_word);
                logic [7:0]  eop = exp_half ? w[19:12] : w[39:32];
                logic [11:0] ead = exp_half ? w[11:0]  : w[31:20];
                check(iss_opcode == eop && iss_addr == ead && iss_half == exp_half,
                      from_rjump ? "R9" : (exp_half ? "R4" : "R3"), "issued instruction",
                      {iss_half, iss_opcode, iss_addr}, {exp_half, eop, ead});
                issued++;
                if (!exp_half) begin
                    exp_half = 1; in_right = 1;
                end else begin
                    wrapped = (exp_word >= 12'd999);
                    exp_word = stepw(exp_word);
                    exp_half = 0; in_right = 0; from_rjump = 0;
                end
            end
        end
        prev_valid = iss_valid; prev_op = iss_opcode; prev_addr = iss_addr; prev_half = iss_half;
        prev_fire = iss_valid && rdy;
        prev_jmp = jump;
        jmp_valid = jump; jmp_target = tgt; jmp_right = rsel; iss_ready = rdy;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(mem_req && mem_addr == 12'd0 && !iss_valid, "R1", "state after reset",
              {mem_req, iss_valid, mem_addr}, {1'b1, 1'b0, 12'd0});
        req_cyc = cyc;
        for (int i = 0; i < 40; i++) tick(100, 0);
        for (int i = 0; i < 2000; i++) tick(70, 1);
        tick(100, 0, 1, 12'd998, 0);
        for (int i = 0; i < 60; i++) tick(100, 0);
        tick(100, 0, 1, 12'd999, 1);
        for (int i = 0; i < 20; i++) tick(100, 0);
        tick(100, 0, 1, 12'd4000, 0);
        for (int i = 0; i < 20; i++) tick(100, 0);
        tick(100, 0, 1, 12'd0, 1);
        for (int i = 0; i < 20; i++) tick(60, 0);
        for (int i = 0; i < 500; i++) tick(20, 0);
        check(issued > 100, "R6", "instructions issued", issued, 101);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual %0d expected < 200000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule